// File: doc/BRIEF.md
# Bus Address Breakpoint Unit

This block watches the memory side of a small 8-bit processor's bus and compares every memory access against a 16-bit watch address. The access may be an instruction fetch, a data read or a data write, so a store to a display buffer at a chosen location trips it just as an instruction fetch would. When the address matches, the selected reaction follows. In one mode a single-cycle non-maskable interrupt request goes to the processor. In the other mode the processor is held on a wait line until an external step pulse lets it go.

A supervisory controller programs the watch address one 4-bit nibble at a time through a narrow write port, and it sets the reaction mode through the same port. These settings sit on their own power-on reset. A reset of the main logic therefore clears the pending reaction but keeps the watch address and the mode, so a supervisor that refreshes them keeps a stable breakpoint across main-logic resets. I/O cycles are never compared.

Top module: `bus_break_unit`

## Requirements
- R1: After power-on reset (`porRst_n` low) the watch address is 0x05E2, the mode is disabled (00), and `nmiReq` and `waitReq` are low.
- R2: A config write with `cfgSel` = k (0..3) replaces address bits [4k+3:4k] with `cfgData` and leaves the other nibbles unchanged. `cfgSel` = 4 loads the mode from `cfgData[1:0]`.
- R3: A memory access (`memReq` high, `ioReq` low) with `rdStb` or `wrStb` high whose `cpuAddr` equals the watch address is a match, whether it is a read or a write.
- R4: An access with `ioReq` high, or with neither strobe high, never causes a reaction, even at the watch address.
- R5: In mode 01, a match drives `nmiReq` high for exactly one cycle, the cycle after the match is sampled, and `waitReq` stays low.
- R6: A match reacts once per bus cycle. The unit re-arms only after `memReq` has been sampled low.
- R7: In mode 10, `waitReq` rises the cycle after the match is sampled and stays high until `stepPulse` is sampled high. It falls in the following cycle.
- R8: In modes 00 and 11, a match produces neither `nmiReq` nor `waitReq`.
- R9: `rst_n` low clears `nmiReq` and `waitReq` but keeps the watch address and the mode.
- R10: If `stepPulse` is sampled in the same cycle as a new match in mode 10, the match wins and `waitReq` rises.
- R11: A `stepPulse` while no wait is held has no effect on `nmiReq` or `waitReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-on reset of the address and mode settings, active low |
| rst_n | input | 1 | Main-logic reset of the reaction state, active low |
| cpuAddr | input | 16 | Processor address bus |
| memReq | input | 1 | Memory request |
| ioReq | input | 1 | I/O request (excludes the cycle from matching) |
| rdStb | input | 1 | Read strobe (fetch or data read) |
| wrStb | input | 1 | Write strobe |
| cfgWe | input | 1 | Config write enable |
| cfgSel | input | 3 | Config target: 0..3 address nibble, 4 mode |
| cfgData | input | 4 | Config write data |
| stepPulse | input | 1 | Step/resume request releasing a held wait |
| nmiReq | output | 1 | Non-maskable interrupt request pulse |
| waitReq | output | 1 | Wait/hold request to the processor |

## Verification
A new match and a step request can land in the same clock cycle. The release path tries to drop the wait while the match path tries to raise it. The bench provokes this with the unit in single-step mode and no wait held: in one cycle it drives a matching access and `stepPulse` together. The next cycle must show `waitReq` high, because the match takes priority. A second conflict is a main-logic reset while a wait is held. It is judged by checking that the wait drops and that the next access at the unchanged watch address triggers again.

// File: rtl/bus_break_pkg.sv
package bus_break_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_NMI  = 2'b01,
    MODE_STEP = 2'b10,
    MODE_RSV  = 2'b11
  } bpMode_e;

  // strobes handed from the datapath to the control
  typedef struct packed {
    logic hit;
    logic modeNmi;
    logic modeStep;
  } bpStrobe_t;

endpackage

// File: rtl/bus_break_regs.sv
module bus_break_regs
  import bus_break_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W = 4,
  parameter logic [ADDR_W-1:0] DEF_ADDR = 16'h05E2,
  localparam int NIBS = ADDR_W / NIB_W,
  localparam int SEL_W = $clog2(NIBS + 1)
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [NIB_W-1:0]  cfgData,
  output bpStrobe_t         strb
);

  localparam logic [SEL_W-1:0] MODE_SEL = SEL_W'(NIBS);

  logic [ADDR_W-1:0] bpAddr;
  bpMode_e modeQ;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] nibQ;
    always_ff @(posedge clk or negedge porRst_n) begin
      if (!porRst_n) nibQ <= DEF_ADDR[g*NIB_W +: NIB_W];
      else if (cfgWe && cfgSel == SEL_W'(g)) nibQ <= cfgData;
    end
    assign bpAddr[g*NIB_W +: NIB_W] = nibQ;
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) modeQ <= MODE_OFF;
    else if (cfgWe && cfgSel == MODE_SEL) modeQ <= bpMode_e'(cfgData[1:0]);
  end

  logic memAccess;
  assign memAccess = memReq && !ioReq && (rdStb || wrStb);

  always_comb begin
    strb.hit      = memAccess && (cpuAddr == bpAddr);
    strb.modeNmi  = (modeQ == MODE_NMI);
    strb.modeStep = (modeQ == MODE_STEP);
  end

  // R2: a mode write lands in the next cycle
  p_mode_load_r2: assert property (@(posedge clk) disable iff (!porRst_n)
    (cfgWe && cfgSel == MODE_SEL) |=> (modeQ == bpMode_e'($past(cfgData[1:0]))));

endmodule

// File: rtl/bus_break_ctrl.sv
module bus_break_ctrl
  import bus_break_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      memReq,
  input  logic      stepPulse,
  input  bpStrobe_t strb,
  output logic      nmiReq,
  output logic      waitReq
);

  logic armedQ;
  logic holdQ;
  logic bpEvent;

  assign bpEvent = strb.hit && armedQ;
  assign waitReq = holdQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armedQ <= 1'b1;
      nmiReq <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      if (bpEvent) armedQ <= 1'b0;
      else if (!memReq) armedQ <= 1'b1;
      nmiReq <= bpEvent && strb.modeNmi;
      if (bpEvent && strb.modeStep) holdQ <= 1'b1;
      else if (stepPulse) holdQ <= 1'b0;
    end
  end

  // R5: the interrupt request lasts a single cycle
  p_nmi_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmiReq |=> !nmiReq);

  // R7: wait stays until a step arrives
  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waitReq && !stepPulse) |=> waitReq);

  // R7: a step without a competing match releases the wait
  p_wait_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waitReq && stepPulse && !strb.hit) |=> !waitReq);

  // R8: the two reactions never start together
  p_one_reaction_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmiReq |-> !$rose(waitReq));

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import bus_break_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NIB_W = 4,
  parameter logic [ADDR_W-1:0] DEF_ADDR = 16'h05E2,
  localparam int NIBS = ADDR_W / NIB_W,
  localparam int SEL_W = $clog2(NIBS + 1)
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [NIB_W-1:0]  cfgData,
  input  logic              stepPulse,
  output logic              nmiReq,
  output logic              waitReq
);

  bpStrobe_t strb;

  bus_break_regs #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .DEF_ADDR(DEF_ADDR)) u_regs (
    .clk(clk), .porRst_n(porRst_n), .cpuAddr(cpuAddr), .memReq(memReq),
    .ioReq(ioReq), .rdStb(rdStb), .wrStb(wrStb), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgData(cfgData), .strb(strb)
  );

  bus_break_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .memReq(memReq), .stepPulse(stepPulse),
    .strb(strb), .nmiReq(nmiReq), .waitReq(waitReq)
  );

  // R4: an interrupt request only follows a memory (non-I/O) cycle
  p_io_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmiReq) |-> $past(memReq && !ioReq));

endmodule

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;

  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic porRst_n, rst_n;
  logic [15:0] cpuAddr;
  logic memReq, ioReq, rdStb, wrStb, cfgWe, stepPulse;
  logic [2:0] cfgSel;
  logic [3:0] cfgData;
  logic nmiReq, waitReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_break_unit u_dut (
    .clk(clk), .porRst_n(porRst_n), .rst_n(rst_n), .cpuAddr(cpuAddr),
    .memReq(memReq), .ioReq(ioReq), .rdStb(rdStb), .wrStb(wrStb),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData), .stepPulse(stepPulse),
    .nmiReq(nmiReq), .waitReq(waitReq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    memReq = 0; ioReq = 0; rdStb = 0; wrStb = 0; stepPulse = 0; cfgWe = 0;
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [3:0] data);
    @(negedge clk);
    cfgWe = 1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic setAddr(input logic [15:0] a);
    for (int k = 0; k < 4; k++) cfgWrite(3'(k), a[k*4 +: 4]);
  endtask

  // one-cycle access; checks outputs the cycle after, then ends the cycle
  task automatic access(input logic [15:0] a, input logic rd, input logic wr,
                        input logic io, input logic expNmi, input logic expWait,
                        input string tag);
    @(negedge clk);
    cpuAddr = a; memReq = 1; ioReq = io; rdStb = rd; wrStb = wr;
    @(negedge clk);
    memReq = 0; ioReq = 0; rdStb = 0; wrStb = 0;
    check(nmiReq, expNmi, {tag, " nmi"});
    check(waitReq, expWait, {tag, " wait"});
    @(negedge clk);
    check(nmiReq, 1'b0, {tag, " nmi ends"});
  endtask

  task automatic step();
    @(negedge clk); stepPulse = 1;
    @(negedge clk); stepPulse = 0;
  endtask

  task automatic t_reset_default();
    check(nmiReq, 1'b0, "R1 nmi at reset");
    check(waitReq, 1'b0, "R1 wait at reset");
    access(16'h05E2, 1, 0, 0, 0, 0, "R1 default mode off");
    cfgWrite(3'd4, 4'h1);
    access(16'h05E2, 1, 0, 0, 1, 0, "R1 default address");
  endtask

  task automatic t_nibbles();
    setAddr(16'hA3C7);
    access(16'hA3C7, 1, 0, 0, 1, 0, "R2 full address");
    access(16'h05E2, 1, 0, 0, 0, 0, "R2 old address gone");
    cfgWrite(3'd2, 4'hF);
    access(16'hA3C7, 1, 0, 0, 0, 0, "R2 nibble2 replaced");
    access(16'hAFC7, 1, 0, 0, 1, 0, "R2 other nibbles kept");
  endtask

  task automatic t_rd_wr_io();
    access(16'hAFC7, 0, 1, 0, 1, 0, "R3 write match");
    access(16'hAFC8, 1, 0, 0, 0, 0, "R3 near miss");
    access(16'hAFC7, 1, 0, 1, 0, 0, "R4 io cycle");
    access(16'hAFC7, 0, 0, 0, 0, 0, "R4 no strobe");
  endtask

  task automatic t_once_per_cycle();
    @(negedge clk);
    cpuAddr = 16'hAFC7; memReq = 1; rdStb = 1;
    @(negedge clk); check(nmiReq, 1'b1, "R6 first");
    @(negedge clk); check(nmiReq, 1'b0, "R5 pulse one cycle");
    @(negedge clk); check(nmiReq, 1'b0, "R6 no retrigger");
    memReq = 0; rdStb = 0;
    @(negedge clk); check(nmiReq, 1'b0, "R6 gap");
    memReq = 1; rdStb = 1;
    @(negedge clk); check(nmiReq, 1'b1, "R6 rearmed");
    memReq = 0; rdStb = 0;
    @(negedge clk);
  endtask

  task automatic t_step_mode();
    cfgWrite(3'd4, 4'h2);
    access(16'hAFC7, 1, 0, 0, 0, 1, "R7 wait rises");
    @(negedge clk); check(waitReq, 1'b1, "R7 wait held");
    step();
    check(waitReq, 1'b0, "R7 released by step");
    step();
    check(waitReq, 1'b0, "R11 idle step");
    check(nmiReq, 1'b0, "R11 idle step nmi");
    // R10: step and new match in the same cycle
    @(negedge clk);
    cpuAddr = 16'hAFC7; memReq = 1; wrStb = 1; stepPulse = 1;
    @(negedge clk);
    memReq = 0; wrStb = 0; stepPulse = 0;
    check(waitReq, 1'b1, "R10 match beats step");
    step();
    check(waitReq, 1'b0, "R10 later release");
  endtask

  task automatic t_off_modes();
    cfgWrite(3'd4, 4'h3);
    access(16'hAFC7, 1, 0, 0, 0, 0, "R8 mode 11");
    cfgWrite(3'd4, 4'h0);
    access(16'hAFC7, 0, 1, 0, 0, 0, "R8 mode 00");
  endtask

  task automatic t_main_reset();
    cfgWrite(3'd4, 4'h2);
    access(16'hAFC7, 1, 0, 0, 0, 1, "R9 hold before reset");
    @(negedge clk); rst_n = 0;
    @(negedge clk); check(waitReq, 1'b0, "R9 reset clears wait");
    rst_n = 1;
    access(16'hAFC7, 1, 0, 0, 0, 1, "R9 settings kept");
    step();
    cfgWrite(3'd4, 4'h1);
    access(16'hAFC7, 1, 0, 0, 1, 0, "R9 nmi after reset");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    cpuAddr = 0; cfgSel = 0; cfgData = 0;
    porRst_n = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    porRst_n = 1; rst_n = 1;
    t_reset_default();
    t_nibbles();
    t_rd_wr_io();
    t_once_per_cycle();
    t_step_mode();
    t_off_modes();
    t_main_reset();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule